// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a bank of already-synchronized input pins and turns selected pin activity into interrupt flags. Each pin has its own trigger mode, held in a small per-pin control word: off, low level, high level, rising edge, falling edge or either edge. Any detected event latches a flag in a shared status word. Software clears flags by writing ones to them. One combined interrupt line is raised while any flag is set.

Software reaches the block through a plain register port: a write strobe, a read strobe, a byte address and a 32-bit data word. Read data appears one cycle after the read strobe. The pins are sampled every clock. Edge modes compare each sample with the one taken a cycle earlier. The register port and the interrupt line are control and status signals, so they carry no valid/ready handshake. Nothing at the port can stall.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every pin's trigger mode is off (code 0x0), every status flag is 0 and `irq_o` is low.
- R2: The control word of pin n is at byte address 4*n, for n from 0 to NUM_PINS-1. Its trigger code sits in bits 19:16, and it is written and read back there. All other bits of a control word read as 0.
- R3: Code 0x0, and every code other than 0x8, 0x9, 0xA, 0xB and 0xC, never sets the pin's flag. Writing zero to a control word therefore turns that pin's detection off.
- R4: Code 0x9 sets the flag on a 0-to-1 change between consecutive samples, code 0xA on a 1-to-0 change, and code 0xB on either change. A pin that does not change sets no flag.
- R5: Code 0x8 sets the flag on every cycle the pin samples 0, and code 0xC on every cycle it samples 1. A clear issued while that level persists leaves the flag set.
- R6: The status word is at byte address 0xA0, with bit n holding pin n's flag. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R7: When a detection event and a clear hit the same flag in the same cycle, the flag ends up set.
- R8: A flag set by an edge stays set, whatever the pin does afterwards, until software clears it.
- R9: `irq_o` is a register that holds the OR of all status flags as they stood one cycle earlier.
- R10: A read returns its data on `reg_rdata_o` in the cycle after `reg_rd_i`. Addresses that map to no register read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Synchronized pin samples |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The bench targets the conflict between a clear and a detection that land on one flag in the same cycle. A design that lets the clear win there drops an edge that has just arrived. It also tries to clear a level-mode flag while the level is still held. A design that honours that clear reports the pin as quiet when it is still active. Unlisted codes are written with every other bit of the word set, which exposes a design that decodes only some bits of the code, or that returns bits from outside the field on readback. Random pin toggling under randomly reconfigured modes checks the edge comparison against the previous sample rather than a stale one, and checks that the one-cycle delay on `irq_o` is neither shortened nor stretched.

// File: rtl/pid_pkg.sv
package pid_pkg;

  localparam int CFG_W = 4;

  typedef enum logic [CFG_W-1:0] {
    TRIG_OFF  = 4'h0,
    TRIG_LOW  = 4'h8,
    TRIG_RISE = 4'h9,
    TRIG_FALL = 4'hA,
    TRIG_BOTH = 4'hB,
    TRIG_HIGH = 4'hC
  } trig_e;

  // Decide whether one pin raises its flag this cycle.
  function automatic logic trig_hit(logic [CFG_W-1:0] code, logic cur, logic prv);
    logic hit;
    case (code)
      TRIG_LOW:  hit = ~cur;
      TRIG_RISE: hit = cur & ~prv;
      TRIG_FALL: hit = ~cur & prv;
      TRIG_BOTH: hit = cur ^ prv;
      TRIG_HIGH: hit = cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic code_known(logic [CFG_W-1:0] code);
    return (code == TRIG_LOW) || (code == TRIG_RISE) || (code == TRIG_FALL) ||
           (code == TRIG_BOTH) || (code == TRIG_HIGH);
  endfunction

endpackage

// File: rtl/pid_cfg_regs.sv
module pid_cfg_regs
  import pid_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [CFG_W-1:0]               field_i,
  output logic [NUM_PINS-1:0][CFG_W-1:0] cfg_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cfg_o[g] <= '0;
      else if (wr_en_i && (idx_i == IDX_W'(g)))   cfg_o[g] <= field_i;
    end
  end

  AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (cfg_o[$past(idx_i)] == $past(field_i))); // R2

endmodule

// File: rtl/pid_detect.sv
module pid_detect
  import pid_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PINS-1:0]            pin_i,
  input  logic [NUM_PINS-1:0][CFG_W-1:0] cfg_i,
  output logic [NUM_PINS-1:0]            event_o
);

  logic [NUM_PINS-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_i;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign event_o[g] = trig_hit(cfg_i[g], pin_i[g], pin_q[g]);

    AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !code_known(cfg_i[g]) |-> !event_o[g]); // R3
    AST_STEADY_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_i[g] inside {TRIG_RISE, TRIG_FALL, TRIG_BOTH}) && (pin_i[g] == pin_q[g]))
        |-> !event_o[g]); // R4
  end

endmodule

// File: rtl/pid_status.sv
module pid_status #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_i) | event_i;
      irq_o    <= |status_o;
    end
  end

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_i) |=> ((status_o & $past(event_i)) == $past(event_i))); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~event_i)) |=> ((status_o & $past(clr_i & ~event_i)) == '0)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_o & $past(status_o & ~clr_i)) == '0)); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|status_o)); // R9

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pid_pkg::*;
#(
  parameter int              NUM_PINS = 32,
  parameter int              ADDR_W   = 8,
  parameter int              CFG_LSB  = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hA0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                irq_o
);

  localparam int              IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [ADDR_W-1:0] CTRL_END = ADDR_W'(4 * NUM_PINS);

  logic                           ctrl_hit;
  logic                           stat_hit;
  logic [IDX_W-1:0]               idx;
  logic [NUM_PINS-1:0][CFG_W-1:0] cfg;
  logic [NUM_PINS-1:0]            events;
  logic [NUM_PINS-1:0]            clr;
  logic [NUM_PINS-1:0]            status;
  logic [31:0]                    rd_word;

  assign ctrl_hit = (reg_addr_i < CTRL_END);
  assign stat_hit = (reg_addr_i == STAT_ADDR);
  assign idx      = reg_addr_i[IDX_W+1:2];
  assign clr      = (reg_wr_i && stat_hit) ? reg_wdata_i[NUM_PINS-1:0] : '0;

  pid_cfg_regs #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (reg_wr_i && ctrl_hit),
    .idx_i   (idx),
    .field_i (reg_wdata_i[CFG_LSB +: CFG_W]),
    .cfg_o   (cfg)
  );

  pid_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .cfg_i   (cfg),
    .event_o (events)
  );

  pid_status #(.NUM_PINS(NUM_PINS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_i  (events),
    .clr_i    (clr),
    .status_o (status),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_word = '0;
    if (ctrl_hit)      rd_word[CFG_LSB +: CFG_W] = cfg[idx];
    else if (stat_hit) rd_word[NUM_PINS-1:0]     = status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_word;
  end

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> $stable(reg_rdata_o)); // R10
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && stat_hit) |=> (reg_rdata_o[NUM_PINS-1:0] == $past(status))); // R6

endmodule

// File: tb/test_pin_irq_detect.sv
`timescale 1ns/1ps
module test_pin_irq_detect;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;

  logic [3:0]  m_cfg [32];
  logic [31:0] m_stat = '0, m_prev = '0;
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  pin_irq_detect i_pin_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic hit(logic [3:0] code, logic cur, logic prv);
    case (code)
      4'h8: return ~cur;
      4'h9: return cur & ~prv;
      4'hA: return ~cur & prv;
      4'hB: return cur ^ prv;
      4'hC: return cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] read_model(logic [7:0] a);
    if (a < 8'h80)   return {12'h0, m_cfg[a[6:2]], 16'h0};
    if (a == 8'hA0)  return m_stat;
    return '0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: model computed from the requirements, then compared.
  task automatic tick();
    logic [31:0] ev, clr, nstat, erd;
    logic        did_rd;
    logic [7:0]  rd_a;
    for (int i = 0; i < 32; i++) ev[i] = hit(m_cfg[i], pin[i], m_prev[i]);
    clr    = (wr && addr == 8'hA0) ? wdata : '0;
    nstat  = (m_stat & ~clr) | ev;          // R7: set wins
    erd    = read_model(addr);
    did_rd = rd;
    rd_a   = addr;
    @(posedge clk);
    m_irq  = |m_stat;
    m_stat = nstat;
    m_prev = pin;
    if (wr && addr < 8'h80) m_cfg[addr[6:2]] = wdata[19:16];
    @(negedge clk);
    check("R9 irq", {31'h0, irq}, {31'h0, m_irq});
    if (did_rd) begin
      if (rd_a < 8'h80)      check("R2 ctrl read", rdata, erd);
      else if (rd_a == 8'hA0) check("R6 status read", rdata, erd);
      else                   check("R10 unmapped read", rdata, erd);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    tick();
    rd = 1'b0;
    d = rdata;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1d5c_0a73));
    for (int i = 0; i < 32; i++) m_cfg[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    rd_reg(8'hA0, d); check("R1 status after reset", d, 32'h0);
    rd_reg(8'h14, d); check("R1 ctrl after reset", d, 32'h0);

    // R2, R3: unlisted code with all bits set reads back only the field
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    rd_reg(8'h0C, d); check("R2 field readback", d, 32'h000F_0000);
    for (int k = 0; k < 4; k++) begin pin[3] = ~pin[3]; tick(); end
    rd_reg(8'hA0, d); check("R3 unlisted code silent", d, 32'h0);

    // R4, R8: rising edge on pin 0
    wr_reg(8'h00, 32'h0009_0000);
    pin[0] = 1'b1; tick(); tick();
    pin[0] = 1'b0; tick();
    rd_reg(8'hA0, d); check("R8 edge flag sticky", d & 32'h1, 32'h1);
    check("R9 irq raised", {31'h0, irq}, 32'h1);
    wr_reg(8'hA0, 32'h1); tick();
    rd_reg(8'hA0, d); check("R4 falling ignored in rise mode", d & 32'h1, 32'h0);

    // R5: high level overrides clear, then clears once level drops
    wr_reg(8'h04, 32'h000C_0000);
    pin[1] = 1'b1; tick();
    wr_reg(8'hA0, 32'h2);
    rd_reg(8'hA0, d); check("R5 level persists over clear", d & 32'h2, 32'h2);
    pin[1] = 1'b0; tick();
    wr_reg(8'hA0, 32'h2);
    rd_reg(8'hA0, d); check("R5 clear after level drop", d & 32'h2, 32'h0);

    // R7: edge and clear in the same cycle
    wr_reg(8'h08, 32'h000B_0000);
    pin[2] = 1'b1; tick();
    pin[2] = 1'b0; wr = 1'b1; addr = 8'hA0; wdata = 32'h4; tick(); wr = 1'b0;
    rd_reg(8'hA0, d); check("R7 set wins over clear", d & 32'h4, 32'h4);

    // R6: writing zeros changes nothing, ones clear
    wr_reg(8'hA0, 32'h0);
    rd_reg(8'hA0, d); check("R6 zero write keeps flag", d & 32'h4, 32'h4);
    wr_reg(8'hA0, 32'hFFFF_FFFF);
    rd_reg(8'hA0, d); check("R6 all-ones clears", d, 32'h0);

    // R3: zero control word disables; R10: unmapped write ignored
    wr_reg(8'h08, 32'h0);
    pin[2] = 1'b1; tick();
    rd_reg(8'hA0, d); check("R3 zero word disables", d & 32'h4, 32'h0);
    wr_reg(8'h84, 32'hFFFF_FFFF);
    rd_reg(8'h84, d); check("R10 unmapped write ignored", d, 32'h0);

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      int op;
      pin ^= $urandom() & $urandom() & $urandom();
      op = $urandom_range(0, 9);
      if (op == 0) begin
        logic [3:0] codes [8] = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'h3, 4'hF};
        wr = 1'b1; addr = 8'($urandom_range(0, 31) * 4);
        wdata = $urandom() & 32'hFFF0_FFFF | {12'h0, codes[$urandom_range(0, 7)], 16'h0};
      end else if (op == 1) begin
        wr = 1'b1; addr = 8'hA0; wdata = $urandom();
      end else if (op <= 4) begin
        rd = 1'b1;
        addr = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 63) * 4) : 8'hA0;
      end
      tick();
      wr = 1'b0; rd = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule